// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block watches a processor bus one cycle at a time and raises a debug break when a cycle matches a condition that software has programmed. Channels A and B each compare the cycle's address and address-space ID against stored values under a bit mask. Each channel also qualifies the match by cycle class: which master drives the cycle (CPU or DMA), whether it is an instruction fetch or a data access, and whether it reads or writes. Channel B can also compare the data value under its own mask.

A match sets a sticky flag. Each channel keeps one flag for CPU cycles and one for DMA cycles. The block produces one registered break request together with a break-kind code. When both channels hit in the same cycle, the block issues a single request and records both flags. Software loads the conditions and clears the flags through a simple write port. The flags are visible directly on an output port.

Top module: `bus_break_unit`

## Requirements
- R1: After reset, `brk_req` is 0, `match_flags` is 0 and every condition register is 0, so neither channel can break until it is configured.
- R2: A channel matches only when the address and the ASID are both equal to the stored values. A set bit in the address mask excludes that address bit from the compare, and a clear bit requires equality.
- R3: The condition register (A at offset 3, B at offset 7) holds three 2-bit groups: master in bits [1:0] (01 CPU, 10 DMA), access in bits [3:2] (01 fetch, 10 data) and direction in bits [5:4] (01 read, 10 write). In each group, 11 accepts either option. All three groups must accept the cycle. Address, ASID and mask sit at offsets 0, 1 and 2 for channel A and at 4, 5 and 6 for channel B.
- R4: If any group of a channel's condition register is 00, that channel never matches.
- R5: Channel B compares data only when condition bit 7 is set and the cycle is a data access. The data value is at offset 8 and the data mask at offset 9, and a set mask bit ignores that data bit. On fetch cycles the data is ignored.
- R6: `brk_req` is high for exactly the one cycle after the edge that samples a matching cycle with `bus_valid` high. A cycle with `bus_valid` low never matches.
- R7: `brk_kind` is valid while `brk_req` is high. The codes are: 0 fetch, break before execution; 1 fetch, break after execution; 2 data access; 3 on-chip I/O or TLB-load cycle (`bus_is_io` high, which overrides the other codes).
- R8: On a fetch match, condition bit 6 of the matching channel selects between code 1 (bit set) and code 0 (bit clear).
- R9: Flags are `match_flags[0]` A-CPU, `[1]` A-DMA, `[2]` B-CPU and `[3]` B-DMA. A match sets the flag for the channel and master on the same edge that raises `brk_req`, and the flag stays set afterwards.
- R10: A write to offset 10 clears each flag whose write-data bit is 0 and leaves alone each flag whose bit is 1. A clear wins over a set in the same cycle.
- R11: When both channels match in one cycle, the block raises a single one-cycle request, sets both channels' flags, and takes `brk_kind` from channel A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 32 | Cycle address |
| bus_asid | input | 8 | Cycle address-space ID |
| bus_data | input | 32 | Cycle data value |
| bus_is_dma | input | 1 | 1 = DMA master, 0 = CPU |
| bus_is_data | input | 1 | 1 = data access, 0 = instruction fetch |
| bus_is_write | input | 1 | 1 = write, 0 = read |
| bus_is_io | input | 1 | Cycle is an on-chip I/O or TLB-load access |
| brk_req | output | 1 | One-cycle break request |
| brk_kind | output | 2 | Break-kind code |
| match_flags | output | 4 | Sticky match flags |

## Verification
A table of single bus cycles runs against fixed configurations of both channels. Each near-miss differs from a hit in exactly one qualifier: address outside the mask, wrong ASID, wrong master, wrong direction, wrong data, or a missing valid. A failure therefore points at that one comparison. Two hit rows, on a CPU cycle and a DMA cycle, show that the flag lands in the right position. An I/O row shows that the kind code overrides the others. Directed runs then reprogram the channels to test, one at a time:
- the execute-after bit
- a 00 group
- flag stickiness and clearing
- clear-versus-set in one cycle
- a coincident two-channel fetch hit, where the channels carry different execute-after bits so that the kind code shows which channel won.

// File: rtl/bbu_pkg.sv
package bbu_pkg;
  localparam int NCH   = 2;
  localparam int NFLAG = 2 * NCH;

  // register offsets
  localparam int CH_STRIDE = 4;
  localparam int OFS_ADDR  = 0;
  localparam int OFS_ASID  = 1;
  localparam int OFS_AMASK = 2;
  localparam int OFS_COND  = 3;
  localparam int RA_DATA   = 8;
  localparam int RA_DMASK  = 9;
  localparam int RA_FLAGS  = 10;
  localparam int COND_W    = 8;

  typedef enum logic [1:0] {
    KIND_FETCH_PRE  = 2'd0,
    KIND_FETCH_POST = 2'd1,
    KIND_DATA       = 2'd2,
    KIND_IO         = 2'd3
  } brk_kind_e;

  // last member is least significant: mst = [1:0]
  typedef struct packed {
    logic       dcmp;
    logic       post;
    logic [1:0] dir;
    logic [1:0] acc;
    logic [1:0] mst;
  } cond_t;

  // selector group: bit0 accepts the first option, bit1 the second
  function automatic logic group_ok(input logic [1:0] sel, input logic second);
    return second ? sel[1] : sel[0];
  endfunction

  function automatic brk_kind_e kind_of(input logic is_io, input logic is_data,
                                        input logic post);
    if (is_io)   return KIND_IO;
    if (is_data) return KIND_DATA;
    return post ? KIND_FETCH_POST : KIND_FETCH_PRE;
  endfunction
endpackage

// File: rtl/bbu_regs.sv
module bbu_regs
  import bbu_pkg::*;
#(
  parameter int AW  = 32,
  parameter int IW  = 8,
  parameter int DW  = 32,
  parameter int WW  = 32,
  parameter int RAW = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [RAW-1:0]            reg_addr,
  input  logic [WW-1:0]             reg_wdata,
  output logic [NCH-1:0][AW-1:0]    cfg_addr,
  output logic [NCH-1:0][AW-1:0]    cfg_amask,
  output logic [NCH-1:0][IW-1:0]    cfg_asid,
  output cond_t [NCH-1:0]           cfg_cond,
  output logic [DW-1:0]             cfg_data,
  output logic [DW-1:0]             cfg_dmask,
  output logic                      flag_wr,
  output logic [NFLAG-1:0]          flag_keep
);
  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  function automatic logic hit_ofs(input logic [RAW-1:0] a, input int ofs);
    return a == RAW'(ofs);
  endfunction

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int BASE = ch * CH_STRIDE;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_addr[ch]  <= '0;
        cfg_amask[ch] <= '0;
        cfg_asid[ch]  <= '0;
        cfg_cond[ch]  <= '0;
      end else if (reg_wr) begin
        if (hit_ofs(reg_addr, BASE + OFS_ADDR))  cfg_addr[ch]  <= reg_wdata[AW-1:0];
        if (hit_ofs(reg_addr, BASE + OFS_AMASK)) cfg_amask[ch] <= reg_wdata[AW-1:0];
        if (hit_ofs(reg_addr, BASE + OFS_ASID))  cfg_asid[ch]  <= reg_wdata[IW-1:0];
        if (hit_ofs(reg_addr, BASE + OFS_COND))  cfg_cond[ch]  <= cond_t'(reg_wdata[COND_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_data  <= '0;
      cfg_dmask <= '0;
    end else if (reg_wr) begin
      if (hit_ofs(reg_addr, RA_DATA))  cfg_data  <= reg_wdata[DW-1:0];
      if (hit_ofs(reg_addr, RA_DMASK)) cfg_dmask <= reg_wdata[DW-1:0];
    end
  end

  assign flag_wr   = reg_wr && hit_ofs(reg_addr, RA_FLAGS);
  assign flag_keep = reg_wdata[NFLAG-1:0];
endmodule

// File: rtl/bbu_chan.sv
module bbu_chan
  import bbu_pkg::*;
#(
  parameter int AW       = 32,
  parameter int IW       = 8,
  parameter int DW       = 32,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic [AW-1:0] cfg_addr,
  input  logic [AW-1:0] cfg_amask,
  input  logic [IW-1:0] cfg_asid,
  input  cond_t         cfg_cond,
  input  logic [DW-1:0] cfg_data,
  input  logic [DW-1:0] cfg_dmask,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [IW-1:0] bus_asid,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_is_dma,
  input  logic          bus_is_data,
  input  logic          bus_is_write,
  input  logic          bus_is_io,
  output logic          hit,
  output brk_kind_e     kind
);
  function automatic logic addr_match(input logic [AW-1:0] a, input logic [AW-1:0] ref_v,
                                      input logic [AW-1:0] ign);
    return ((a ^ ref_v) & ~ign) == '0;
  endfunction

  function automatic logic data_match(input logic [DW-1:0] d, input logic [DW-1:0] ref_v,
                                      input logic [DW-1:0] ign);
    return ((d ^ ref_v) & ~ign) == '0;
  endfunction

  logic addr_ok, asid_ok, class_ok, data_ok;

  assign addr_ok  = addr_match(bus_addr, cfg_addr, cfg_amask);
  assign asid_ok  = (bus_asid == cfg_asid);
  assign class_ok = group_ok(cfg_cond.mst, bus_is_dma)
                 && group_ok(cfg_cond.acc, bus_is_data)
                 && group_ok(cfg_cond.dir, bus_is_write);

  if (HAS_DATA) begin : g_data
    assign data_ok = !cfg_cond.dcmp || !bus_is_data
                  || data_match(bus_data, cfg_data, cfg_dmask);
  end else begin : g_nodata
    logic unused_data;
    assign unused_data = ^{cfg_data, cfg_dmask, bus_data, cfg_cond.dcmp};
    assign data_ok = 1'b1;
  end

  assign hit  = bus_valid && addr_ok && asid_ok && class_ok && data_ok;
  assign kind = kind_of(bus_is_io, bus_is_data, cfg_cond.post);
endmodule

// File: rtl/bbu_flags.sv
module bbu_flags
  import bbu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   ch_hit,
  input  logic             bus_is_dma,
  input  logic             clr_wr,
  input  logic [NFLAG-1:0] clr_keep,
  output logic [NFLAG-1:0] flags
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    for (genvar m = 0; m < 2; m++) begin : g_mst
      localparam int IDX = ch * 2 + m;
      logic set_ev, clr_ev;
      assign set_ev = ch_hit[ch] && (bus_is_dma == 1'(m));
      assign clr_ev = clr_wr && !clr_keep[IDX];
      always_ff @(posedge clk) begin
        if (!rst_n)      flags[IDX] <= 1'b0;
        else if (clr_ev) flags[IDX] <= 1'b0;
        else if (set_ev) flags[IDX] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import bbu_pkg::*;
#(
  parameter int AW  = 32,
  parameter int IW  = 8,
  parameter int DW  = 32,
  parameter int WW  = 32,
  parameter int RAW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [WW-1:0]  reg_wdata,
  input  logic           bus_valid,
  input  logic [AW-1:0]  bus_addr,
  input  logic [IW-1:0]  bus_asid,
  input  logic [DW-1:0]  bus_data,
  input  logic           bus_is_dma,
  input  logic           bus_is_data,
  input  logic           bus_is_write,
  input  logic           bus_is_io,
  output logic           brk_req,
  output logic [1:0]     brk_kind,
  output logic [NFLAG-1:0] match_flags
);
  logic [NCH-1:0][AW-1:0] cfg_addr, cfg_amask;
  logic [NCH-1:0][IW-1:0] cfg_asid;
  cond_t [NCH-1:0]        cfg_cond;
  logic [DW-1:0]          cfg_data, cfg_dmask;
  logic                   flag_wr;
  logic [NFLAG-1:0]       flag_keep;

  // named internal events for the checker
  logic [NCH-1:0]         ch_hit;
  brk_kind_e              ch_kind [NCH];
  brk_kind_e              sel_kind;
  logic [COND_W-1:0]      cond_a, cond_b;
  brk_kind_e              kind_q;

  bbu_regs #(.AW(AW), .IW(IW), .DW(DW), .WW(WW), .RAW(RAW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cfg_addr(cfg_addr), .cfg_amask(cfg_amask),
    .cfg_asid(cfg_asid), .cfg_cond(cfg_cond), .cfg_data(cfg_data),
    .cfg_dmask(cfg_dmask), .flag_wr(flag_wr), .flag_keep(flag_keep)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    bbu_chan #(.AW(AW), .IW(IW), .DW(DW), .HAS_DATA(ch == NCH - 1)) u_chan (
      .cfg_addr(cfg_addr[ch]), .cfg_amask(cfg_amask[ch]), .cfg_asid(cfg_asid[ch]),
      .cfg_cond(cfg_cond[ch]), .cfg_data(cfg_data), .cfg_dmask(cfg_dmask),
      .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_asid(bus_asid),
      .bus_data(bus_data), .bus_is_dma(bus_is_dma), .bus_is_data(bus_is_data),
      .bus_is_write(bus_is_write), .bus_is_io(bus_is_io),
      .hit(ch_hit[ch]), .kind(ch_kind[ch])
    );
  end

  // lowest-numbered hitting channel supplies the kind
  always_comb begin
    sel_kind = KIND_FETCH_PRE;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (ch_hit[i]) sel_kind = ch_kind[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_req <= 1'b0;
      kind_q  <= KIND_FETCH_PRE;
    end else begin
      brk_req <= |ch_hit;
      if (|ch_hit) kind_q <= sel_kind;
    end
  end

  assign brk_kind = kind_q;
  assign cond_a   = cfg_cond[0];
  assign cond_b   = cfg_cond[NCH-1];

  bbu_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ch_hit(ch_hit), .bus_is_dma(bus_is_dma),
    .clr_wr(flag_wr), .clr_keep(flag_keep), .flags(match_flags)
  );
endmodule

// File: rtl/bus_break_unit_chk.sv
module bus_break_unit_chk #(
  parameter int RAW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [RAW-1:0] reg_addr,
  input logic           bus_is_io,
  input logic [1:0]     ch_hit,
  input logic [7:0]     cond_a,
  input logic [7:0]     cond_b,
  input logic           brk_req,
  input logic [1:0]     brk_kind,
  input logic [3:0]     match_flags
);
  assert_disabled_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ch_hit[0] |-> (cond_a[1:0] != 2'b00 && cond_a[3:2] != 2'b00 && cond_a[5:4] != 2'b00));

  assert_disabled_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ch_hit[1] |-> (cond_b[1:0] != 2'b00 && cond_b[3:2] != 2'b00 && cond_b[5:4] != 2'b00));

  assert_req_has_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(|ch_hit));

  assert_hit_gives_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_hit) |=> brk_req);

  assert_io_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && $past(bus_is_io)) |-> brk_kind == 2'd3);

  assert_flag_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(match_flags & ~$past(match_flags))) |-> brk_req);

  assert_flag_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(match_flags) & ~match_flags)) |-> $past(reg_wr && reg_addr == RAW'(10)));
endmodule

bind bus_break_unit bus_break_unit_chk #(.RAW(RAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .bus_is_io(bus_is_io), .ch_hit(ch_hit), .cond_a(cond_a), .cond_b(cond_b),
  .brk_req(brk_req), .brk_kind(brk_kind), .match_flags(match_flags)
);

// File: tb/bus_break_unit_test.sv
module bus_break_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [7:0]  bus_asid = '0;
  logic [31:0] bus_data = '0;
  logic        bus_is_dma = 1'b0, bus_is_data = 1'b0, bus_is_write = 1'b0, bus_is_io = 1'b0;
  logic        brk_req;
  logic [1:0]  brk_kind;
  logic [3:0]  match_flags;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bus_break_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_asid(bus_asid), .bus_data(bus_data), .bus_is_dma(bus_is_dma),
    .bus_is_data(bus_is_data), .bus_is_write(bus_is_write), .bus_is_io(bus_is_io),
    .brk_req(brk_req), .brk_kind(brk_kind), .match_flags(match_flags)
  );

  typedef struct packed {
    logic        valid;
    logic [31:0] addr;
    logic [7:0]  asid;
    logic [31:0] data;
    logic        dma;
    logic        isdata;
    logic        wr;
    logic        io;
    logic        req;
    logic [1:0]  kind;
    logic [3:0]  flags;
  } vec_t;

  // A: addr 1000_0000/mask FF, asid 05, CPU fetch read.  B: addr 2000_0040/mask 0F, asid 07,
  // any master, data write, data CAFE_xxxx.
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h1000_0034, 8'h05, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'b0001}, // R2 R3 R9
    '{1'b1, 32'h1000_0134, 8'h05, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000}, // R2 addr
    '{1'b1, 32'h1000_0034, 8'h06, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000}, // R2 asid
    '{1'b1, 32'h1000_0034, 8'h05, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000}, // R3 master
    '{1'b1, 32'h1000_0034, 8'h05, 32'h0,         1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000}, // R3 access
    '{1'b1, 32'h2000_004C, 8'h07, 32'hCAFE_1234, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 4'b0100}, // R5 R7 R9
    '{1'b1, 32'h2000_004C, 8'h07, 32'hCAFE_1234, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 4'b1000}, // R9 dma
    '{1'b1, 32'h2000_004C, 8'h07, 32'hCAFF_1234, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 4'b0000}, // R5 data
    '{1'b1, 32'h2000_004C, 8'h07, 32'hCAFE_1234, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000}, // R3 dir
    '{1'b1, 32'h2000_0041, 8'h07, 32'hCAFE_0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 4'b0100}, // R7 io
    '{1'b0, 32'h1000_0034, 8'h05, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000}  // R6 valid
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic drive(input vec_t v);
    bus_valid = v.valid; bus_addr = v.addr; bus_asid = v.asid; bus_data = v.data;
    bus_is_dma = v.dma; bus_is_data = v.isdata; bus_is_write = v.wr; bus_is_io = v.io;
  endtask

  // one bus cycle; outputs sampled just after the edge that registers it
  task automatic bus_cycle(input vec_t v);
    @(negedge clk);
    drive(v);
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    bus_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  function automatic vec_t mk(input logic [31:0] a, input logic [7:0] id, input logic dma,
                              input logic isd, input logic wr, input logic [31:0] d);
    vec_t v;
    v = '0;
    v.valid = 1'b1; v.addr = a; v.asid = id; v.dma = dma; v.isdata = isd; v.wr = wr; v.data = d;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset brk_req", {31'b0, brk_req}, 32'd0);
    check("R1 reset flags", {28'b0, match_flags}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // unconfigured channels must stay silent
    bus_cycle(VECS[0]);
    check("R1 unconfigured req", {31'b0, brk_req}, 32'd0);
    check("R1 unconfigured flags", {28'b0, match_flags}, 32'd0);

    reg_write(4'd0, 32'h1000_0000);
    reg_write(4'd1, 32'h05);
    reg_write(4'd2, 32'h0000_00FF);
    reg_write(4'd3, 32'h15);
    reg_write(4'd4, 32'h2000_0040);
    reg_write(4'd5, 32'h07);
    reg_write(4'd6, 32'h0000_000F);
    reg_write(4'd7, 32'hAB);
    reg_write(4'd8, 32'hCAFE_0000);
    reg_write(4'd9, 32'h0000_FFFF);

    for (int i = 0; i < NV; i++) begin
      reg_write(4'd10, 32'h0);
      bus_cycle(VECS[i]);
      check($sformatf("R6 vec%0d brk_req", i), {31'b0, brk_req}, {31'b0, VECS[i].req});
      if (VECS[i].req)
        check($sformatf("R7 vec%0d brk_kind", i), {30'b0, brk_kind}, {30'b0, VECS[i].kind});
      check($sformatf("R9 vec%0d flags", i), {28'b0, match_flags}, {28'b0, VECS[i].flags});
    end

    // R8: execute-after bit on channel A
    reg_write(4'd10, 32'h0);
    reg_write(4'd3, 32'h55);
    bus_cycle(VECS[0]);
    check("R8 post kind", {30'b0, brk_kind}, 32'd1);
    check("R8 post req", {31'b0, brk_req}, 32'd1);

    // R4: a 00 group disables the channel
    reg_write(4'd10, 32'h0);
    reg_write(4'd3, 32'h05);
    bus_cycle(VECS[0]);
    check("R4 dir00 req", {31'b0, brk_req}, 32'd0);
    check("R4 dir00 flags", {28'b0, match_flags}, 32'd0);
    reg_write(4'd3, 32'h14);
    bus_cycle(VECS[0]);
    check("R4 mst00 req", {31'b0, brk_req}, 32'd0);
    reg_write(4'd3, 32'h15);

    // R9/R6/R10: sticky flag, one-cycle pulse, write-0 clear
    reg_write(4'd10, 32'h0);
    bus_cycle(VECS[0]);
    check("R9 set flag", {28'b0, match_flags}, 32'd1);
    idle_cycle();
    check("R6 pulse ends", {31'b0, brk_req}, 32'd0);
    check("R9 flag sticky", {28'b0, match_flags}, 32'd1);
    reg_write(4'd10, 32'hF);
    check("R10 write one keeps", {28'b0, match_flags}, 32'd1);
    reg_write(4'd10, 32'hE);
    check("R10 write zero clears", {28'b0, match_flags}, 32'd0);

    // R10: clear wins over a set in the same cycle
    @(negedge clk);
    drive(VECS[0]);
    reg_wr = 1'b1; reg_addr = 4'd10; reg_wdata = 32'h0;
    @(posedge clk); #1;
    reg_wr = 1'b0; bus_valid = 1'b0;
    check("R10 clear priority flags", {28'b0, match_flags}, 32'd0);
    check("R10 clear priority req", {31'b0, brk_req}, 32'd1);

    // R11 + R5: both channels on one fetch; B data compare ignored on fetch
    reg_write(4'd0, 32'h2000_0040);
    reg_write(4'd1, 32'h07);
    reg_write(4'd7, 32'hD5);
    reg_write(4'd10, 32'h0);
    bus_cycle(mk(32'h2000_0044, 8'h07, 1'b0, 1'b0, 1'b0, 32'h0));
    check("R11 coincident req", {31'b0, brk_req}, 32'd1);
    check("R11 kind from A", {30'b0, brk_kind}, 32'd0);
    check("R11 both flags (R5 fetch ignores data)", {28'b0, match_flags}, 32'b0101);
    idle_cycle();
    check("R11 single pulse", {31'b0, brk_req}, 32'd0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule